// File: doc/BRIEF.md
# Codec Channel-Mode and Power Sequencer

This block is the control sequencer of a telephony PCM codec. It watches the transmit and receive frame-sync pins, a combined receive master-clock / power-down pin, and the receive bit-clock / rate-select pin. Every pin is resynchronised into a fast system clock domain. A pin counts as toggling when an edge of either polarity has been seen within a window of system clocks. From that activity the block picks one of four channel modes: off, transmit half channel, receive half channel and full duplex. It reports the mode on a 2-bit output and drives the enable outputs that stand in for the analog bias and the digital output drivers.

The block also chooses the master clock for the internal sequencing and decides whether the receiver borrows the transmit bit clock. It reports the master-clock rate that the rest of the codec must assume, given the companding law and the state of the select pin. An idle timer restarts on every frame-sync rising edge. When both syncs stop, the current mode holds until that timer runs out, and then the block drops to off. After a wake-up the transmit data and time-slot drivers stay disabled until enough transmit frame syncs have been seen.

Top module: `codec_mode_ctl`

## Requirements
- R1: `mode_o` encodes 2'b00 = off, 2'b01 = transmit half, 2'b10 = receive half and 2'b11 = duplex. After reset the mode is off, and `power_on_o`, `tx_drive_en_o` and `rx_path_en_o` are all low.
- R2: While `rxmck_pd_i` sits at a static high level (no edge within `CLK_WINDOW` cycles), the mode is off, whatever the frame syncs do.
- R3: The block leaves off only when `rxmck_pd_i` is low or toggling and at least one frame sync has had an edge within `FS_WINDOW` cycles. With no frame-sync activity it stays off.
- R4: When both frame syncs are active, the mode is duplex and `rx_path_en_o` is high.
- R5: `tx_drive_en_o` stays low after a wake-up until the second `txfs_i` rising edge that arrives once the block is out of off. The edge that woke the block does not count.
- R6: When only the transmit sync is active, the mode is transmit half and `rx_path_en_o` is low, so receive data is ignored and the receive output sits at mid-scale. An enabled transmit driver stays enabled.
- R7: When only the receive sync is active, the mode is receive half and `tx_drive_en_o` is low.
- R8: `use_rx_mclk_o` is high only in receive half mode with `rxmck_pd_i` toggling. In duplex, and in receive half with that pin static, it is low.
- R9: `share_tx_bclk_o` is high when `rxbck_sel_i` is static, and low when it toggles.
- R10: With `alaw_i` = 0, `mclk_rate_o` is 0 (1.536 MHz) when `rxbck_sel_i` is high or toggling, and 1 (1.544 MHz) when it is low.
- R11: With `alaw_i` = 1, `mclk_rate_o` is 2 (2.048 MHz) when `rxbck_sel_i` is high or toggling, and 0 (1.536 MHz) when it is low.
- R12: Every frame-sync rising edge restarts the idle timer. Sync pulses spaced wider than `FS_WINDOW` but closer than `IDLE_LIMIT` keep the block powered, and the last mode holds between them.
- R13: Once no frame-sync rising edge has arrived for `IDLE_LIMIT` cycles, the mode drops to off and `tx_drive_en_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample every pin |
| rst_n | input | 1 | Active-low asynchronous reset |
| txfs_i | input | 1 | Transmit frame-sync pin |
| rxfs_i | input | 1 | Receive frame-sync pin |
| rxmck_pd_i | input | 1 | Receive master clock, or static power-down level |
| rxbck_sel_i | input | 1 | Receive bit clock, or static rate-select level |
| alaw_i | input | 1 | Companding law: 0 = mu-law, 1 = A-law (static) |
| mode_o | output | 2 | Channel mode code |
| power_on_o | output | 1 | Analog bias enable (mode not off) |
| tx_drive_en_o | output | 1 | Enable for the transmit data and time-slot drivers |
| rx_path_en_o | output | 1 | Receive path enable; low mutes the output to mid-scale |
| use_rx_mclk_o | output | 1 | Internal master clock taken from the receive master-clock pin |
| share_tx_bclk_o | output | 1 | Receiver uses the transmit bit clock |
| mclk_rate_o | output | 2 | Expected master clock: 0 = 1.536, 1 = 1.544, 2 = 2.048 MHz |

## Verification
The bench goes after the wake-up gate on the transmit drivers. A design that counted the waking edge would enable the drivers one frame early. It also checks that a static high on the power pin overrides running syncs, where a design that tested the level without the activity would shut down whenever the master clock toggles. The rate select is swept over both laws and all three pin states: low, high and toggling. A swapped table or a missing toggle case shows up as the wrong rate code. Slow sync pulses, spaced wider than the activity window, show whether the idle timer truly restarts. A design that timed from the first pulse, or that fell to off as soon as both syncs went idle, would power down while traffic continues.

// File: rtl/codec_mode_pkg.sv
package codec_mode_pkg;

   typedef enum logic [1:0] {
      MODE_OFF     = 2'b00,
      MODE_TX_HALF = 2'b01,
      MODE_RX_HALF = 2'b10,
      MODE_DUPLEX  = 2'b11
   } chan_mode_t;

   typedef enum logic [1:0] {
      RATE_1536 = 2'd0,
      RATE_1544 = 2'd1,
      RATE_2048 = 2'd2
   } mclk_rate_t;

endpackage

// File: rtl/pin_activity.sv
module pin_activity #(
   parameter int SYNC_STAGES = 2,
   parameter int WINDOW      = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic active_o
);
   localparam int CW = $clog2(WINDOW + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pin_activity: SYNC_STAGES must be at least 2");
   end
   if (WINDOW < 2) begin : g_bad_window
      $error("pin_activity: WINDOW must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   prev_q;
   logic [CW-1:0]          win_q;
   logic                   edge_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[SYNC_STAGES-2:0], pin_i};
         prev_q  <= chain_q[SYNC_STAGES-1];
      end
   end

   assign edge_seen = chain_q[SYNC_STAGES-1] ^ prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
      end else if (edge_seen) begin
         win_q <= CW'(WINDOW);
      end else if (win_q != '0) begin
         win_q <= win_q - 1'b1;
      end
   end

   assign level_o  = chain_q[SYNC_STAGES-1];
   assign active_o = (win_q != '0);
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
   parameter int LIMIT = 200000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   output logic expired_o
);
   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("idle_timer: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CW'(LIMIT);
      end else if (restart_i) begin
         cnt_q <= '0;
      end else if (cnt_q != CW'(LIMIT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/codec_mode_ctl.sv
module codec_mode_ctl
   import codec_mode_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int CLK_WINDOW     = 16,
   parameter int FS_WINDOW      = 16384,
   parameter int IDLE_LIMIT     = 200000,
   parameter int TX_GATE_PULSES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       txfs_i,
   input  logic       rxfs_i,
   input  logic       rxmck_pd_i,
   input  logic       rxbck_sel_i,
   input  logic       alaw_i,
   output logic [1:0] mode_o,
   output logic       power_on_o,
   output logic       tx_drive_en_o,
   output logic       rx_path_en_o,
   output logic       use_rx_mclk_o,
   output logic       share_tx_bclk_o,
   output logic [1:0] mclk_rate_o
);
   localparam int GW = $clog2(TX_GATE_PULSES + 1);

   if (TX_GATE_PULSES < 1) begin : g_bad_gate
      $error("codec_mode_ctl: TX_GATE_PULSES must be at least 1");
   end
   if (FS_WINDOW >= IDLE_LIMIT) begin : g_bad_idle
      $error("codec_mode_ctl: IDLE_LIMIT must exceed FS_WINDOW");
   end

   logic txfs_lvl, txfs_act, rxfs_lvl, rxfs_act;
   logic mck_lvl, mck_act, bck_lvl, bck_act;

   pin_activity #(.SYNC_STAGES(SYNC_STAGES), .WINDOW(FS_WINDOW)) u_txfs (
      .clk(clk), .rst_n(rst_n), .pin_i(txfs_i), .level_o(txfs_lvl), .active_o(txfs_act));
   pin_activity #(.SYNC_STAGES(SYNC_STAGES), .WINDOW(FS_WINDOW)) u_rxfs (
      .clk(clk), .rst_n(rst_n), .pin_i(rxfs_i), .level_o(rxfs_lvl), .active_o(rxfs_act));
   pin_activity #(.SYNC_STAGES(SYNC_STAGES), .WINDOW(CLK_WINDOW)) u_mck (
      .clk(clk), .rst_n(rst_n), .pin_i(rxmck_pd_i), .level_o(mck_lvl), .active_o(mck_act));
   pin_activity #(.SYNC_STAGES(SYNC_STAGES), .WINDOW(CLK_WINDOW)) u_bck (
      .clk(clk), .rst_n(rst_n), .pin_i(rxbck_sel_i), .level_o(bck_lvl), .active_o(bck_act));

   // Rising-edge detection on the synchronised frame syncs.
   logic txfs_prev_q, rxfs_prev_q, txfs_rise, rxfs_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txfs_prev_q <= 1'b0;
         rxfs_prev_q <= 1'b0;
      end else begin
         txfs_prev_q <= txfs_lvl;
         rxfs_prev_q <= rxfs_lvl;
      end
   end

   assign txfs_rise = txfs_lvl & ~txfs_prev_q;
   assign rxfs_rise = rxfs_lvl & ~rxfs_prev_q;

   logic idle_exp;

   idle_timer #(.LIMIT(IDLE_LIMIT)) u_idle (
      .clk(clk), .rst_n(rst_n), .restart_i(txfs_rise | rxfs_rise), .expired_o(idle_exp));

   // Mode selection.
   logic       force_off;
   chan_mode_t mode_q, mode_nxt;

   assign force_off = mck_lvl & ~mck_act;

   always_comb begin
      mode_nxt = mode_q;
      if (force_off || idle_exp) begin
         mode_nxt = MODE_OFF;
      end else begin
         case ({txfs_act, rxfs_act})
            2'b11:   mode_nxt = MODE_DUPLEX;
            2'b10:   mode_nxt = MODE_TX_HALF;
            2'b01:   mode_nxt = MODE_RX_HALF;
            default: mode_nxt = mode_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_OFF;
      else        mode_q <= mode_nxt;
   end

   // Transmit driver gate: count transmit sync rising edges after wake-up.
   logic [GW-1:0] gate_q;
   logic          tx_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= '0;
      end else if (mode_q == MODE_OFF) begin
         gate_q <= '0;
      end else if (txfs_rise && gate_q != GW'(TX_GATE_PULSES)) begin
         gate_q <= gate_q + 1'b1;
      end
   end

   assign tx_mode = (mode_q == MODE_DUPLEX) || (mode_q == MODE_TX_HALF);

   // Expected master-clock rate.
   logic       sel_high;
   mclk_rate_t rate;

   assign sel_high = bck_act | bck_lvl;

   always_comb begin
      if (alaw_i) rate = sel_high ? RATE_2048 : RATE_1536;
      else        rate = sel_high ? RATE_1536 : RATE_1544;
   end

   assign mode_o          = mode_q;
   assign power_on_o      = (mode_q != MODE_OFF);
   assign tx_drive_en_o   = tx_mode && (gate_q == GW'(TX_GATE_PULSES));
   assign rx_path_en_o    = (mode_q == MODE_DUPLEX) || (mode_q == MODE_RX_HALF);
   assign use_rx_mclk_o   = (mode_q == MODE_RX_HALF) && mck_act;
   assign share_tx_bclk_o = ~bck_act;
   assign mclk_rate_o     = rate;
endmodule

// File: rtl/codec_mode_chk.sv
module codec_mode_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode,
   input logic       power_on,
   input logic       tx_drv,
   input logic       rx_en,
   input logic       rx_mclk,
   input logic       force_off,
   input logic       txfs_act,
   input logic       rxfs_act
);
   AST_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      force_off |=> (mode == 2'b00)); // R2

   AST_WAKE_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == 2'b00 && mode != 2'b00) |-> $past(txfs_act || rxfs_act)); // R3

   AST_WAKE_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(power_on) |-> !tx_drv); // R5

   AST_RX_PATH_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_en |-> (mode == 2'b11 || mode == 2'b10)); // R6

   AST_TX_DRV_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_drv |-> (mode == 2'b11 || mode == 2'b01)); // R7

   AST_RX_MCLK_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_mclk |-> (mode == 2'b10)); // R8
endmodule

bind codec_mode_ctl codec_mode_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode_o), .power_on(power_on_o),
   .tx_drv(tx_drive_en_o), .rx_en(rx_path_en_o), .rx_mclk(use_rx_mclk_o),
   .force_off(force_off), .txfs_act(txfs_act), .rxfs_act(rxfs_act));

// File: tb/test_codec_mode_ctl.sv
module test_codec_mode_ctl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic txfs = 1'b0, rxfs = 1'b0, mck = 1'b0, bck = 1'b0, alaw = 1'b0;
   logic [1:0] mode;
   logic power_on, tx_drv, rx_en, rx_mclk, share_bclk;
   logic [1:0] rate;

   int checks = 0;
   int fails  = 0;
   bit tx_run = 0, rx_run = 0;
   int fs_period = 40;
   int tx_pulses = 0;
   int mck_mode = 0;   // 0 low, 1 high, 2 toggling
   int bck_mode = 1;

   always #2 clk = ~clk;

   codec_mode_ctl #(
      .SYNC_STAGES(2), .CLK_WINDOW(16), .FS_WINDOW(64),
      .IDLE_LIMIT(400), .TX_GATE_PULSES(2)
   ) i_codec_mode_ctl (
      .clk(clk), .rst_n(rst_n), .txfs_i(txfs), .rxfs_i(rxfs),
      .rxmck_pd_i(mck), .rxbck_sel_i(bck), .alaw_i(alaw),
      .mode_o(mode), .power_on_o(power_on), .tx_drive_en_o(tx_drv),
      .rx_path_en_o(rx_en), .use_rx_mclk_o(rx_mclk),
      .share_tx_bclk_o(share_bclk), .mclk_rate_o(rate));

   initial begin : txfs_drv
      forever begin
         @(negedge clk);
         if (tx_run) begin
            txfs = 1'b1;
            tx_pulses++;
            repeat (4) @(negedge clk);
            txfs = 1'b0;
            repeat (fs_period - 5) @(negedge clk);
         end
      end
   end

   initial begin : rxfs_drv
      forever begin
         @(negedge clk);
         if (rx_run) begin
            rxfs = 1'b1;
            repeat (4) @(negedge clk);
            rxfs = 1'b0;
            repeat (fs_period - 5) @(negedge clk);
         end
      end
   end

   initial begin : mck_drv
      forever begin
         repeat (3) @(negedge clk);
         if (mck_mode == 2) mck = ~mck;
         else               mck = (mck_mode == 1);
      end
   end

   initial begin : bck_drv
      forever begin
         repeat (4) @(negedge clk);
         if (bck_mode == 2) bck = ~bck;
         else               bck = (bck_mode == 1);
      end
   end

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : main
      settle(5);
      rst_n = 1'b1;
      settle(1);
      // R1 reset state
      check("R1 reset mode", mode, 0);
      check("R1 reset power", power_on, 0);
      check("R1 reset tx", tx_drv, 0);
      check("R1 reset rx", rx_en, 0);
      settle(50);
      // R3 no frame sync -> still off
      check("R3 no sync stays off", mode, 0);

      tx_run = 1;
      rx_run = 1;
      wait (tx_pulses == 2);
      settle(20);
      check("R4 duplex mode", mode, 3);
      check("R4 rx path on", rx_en, 1);
      check("R5 tx gate after one counted edge", tx_drv, 0);
      wait (tx_pulses == 3);
      settle(20);
      check("R5 tx gate after two counted edges", tx_drv, 1);

      rx_run = 0;
      settle(150);
      check("R6 tx half mode", mode, 1);
      check("R6 rx path muted", rx_en, 0);
      check("R6 tx driver kept", tx_drv, 1);

      tx_run = 0;
      rx_run = 1;
      settle(150);
      check("R7 rx half mode", mode, 2);
      check("R7 tx driver off", tx_drv, 0);
      check("R7 rx path on", rx_en, 1);

      mck_mode = 2;
      settle(60);
      check("R8 rx mclk in rx half", rx_mclk, 1);
      mck_mode = 0;
      settle(60);
      check("R8 static mclk pin", rx_mclk, 0);
      mck_mode = 2;
      tx_run = 1;
      settle(150);
      check("R8 duplex uses tx mclk", rx_mclk, 0);
      check("R4 duplex with toggling pin", mode, 3);

      // R9 R10 R11 sweep of law and select state
      for (int law = 0; law < 2; law++) begin
         for (int sel = 0; sel < 3; sel++) begin
            int exp_rate;
            bit hi;
            alaw = law[0];
            bck_mode = sel;
            settle(60);
            hi = (sel != 0);
            if (law == 1) exp_rate = hi ? 2 : 0;
            else          exp_rate = hi ? 0 : 1;
            check(law == 1 ? "R11 A-law rate" : "R10 mu-law rate", rate, exp_rate);
            check("R9 bit clock sharing", share_bclk, (sel != 2) ? 1 : 0);
         end
      end

      // R2 static high power pin
      mck_mode = 1;
      settle(60);
      check("R2 forced off", mode, 0);
      check("R2 tx driver off", tx_drv, 0);
      mck_mode = 0;
      settle(30);
      check("R3 wake with low pin", mode, 3);
      check("R5 tx gate closed after wake", tx_drv, 0);

      // R12 slow pulses keep the block alive
      fs_period = 300;
      settle(1500);
      check("R12 powered with slow pulses", power_on, 1);

      // R13 idle drop
      fs_period = 40;
      settle(400);
      tx_run = 0;
      rx_run = 0;
      settle(200);
      check("R12 mode held before limit", power_on, 1);
      settle(400);
      check("R13 off after idle", mode, 0);
      check("R13 tx driver off", tx_drv, 0);

      tx_run = 1;
      settle(150);
      check("R3 wake on one sync", mode, 1);

      finish_run();
   end
endmodule